// File: doc/BRIEF.md
# Segmented Guest Address Translator

An 8-bit host processor that runs a 16-bit segmented guest can hand address arithmetic to this block. The host loads a 16-bit segment and a 16-bit offset one byte at a time. Each byte goes through a 3-bit select code paired with a synchronous strobe. The block adds the shifted segment to the offset and drives the sum as the guest RAM address. It then moves single bytes between the host data bus and that RAM on a read or write command.

Guest RAM is reachable only through this block, so none of it sits in the host's own memory map. A stored mode bit sets the segment shift. The classic shift of four bits gives a 20-bit space of 1 MB. The wide shift of eight bits gives a 24-bit space of 16 MB. Both modes use the same register loads and access commands, so interpreter code runs unchanged in either mode apart from the single command that picks the mode.

Top module: `seg_xlate`

## Requirements
- R1: After reset the segment and offset are zero, the mode is classic (mode_o = 0), ram_addr is 0, ram_rd, ram_wr and host_rvalid are 0.
- R2: With host_stb high, select codes 0, 1, 2 and 3 load host_wdata into offset bits 7:0, offset bits 15:8, segment bits 7:0 and segment bits 15:8 respectively, effective from the cycle after the strobe.
- R3: In classic mode ram_addr equals ((segment * 16) + offset) modulo 2^20. Bits 23:20 are zero, and a carry out of bit 19 is dropped.
- R4: In wide mode ram_addr equals ((segment * 256) + offset) modulo 2^24.
- R5: Select code 6 puts the block in classic mode and select code 7 puts it in wide mode. The value of host_wdata has no effect on either command.
- R6: Select code 4 raises ram_rd for exactly one cycle, in the cycle after the strobe. In the following cycle host_rdata holds the byte ram_rdata carried while ram_rd was high, and host_rvalid is 1.
- R7: Select code 5 raises ram_wr for exactly one cycle, in the cycle after the strobe, with ram_wdata equal to the host_wdata given with the strobe.
- R8: While host_stb is low, host_sel and host_wdata are ignored: the address, mode, ram_rd and ram_wr do not change.
- R9: host_rvalid falls in the cycle ram_rd is raised and stays low until the read data is captured.
- R10: ram_rd and ram_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_stb | input | 1 | Host access strobe, one cycle per command |
| host_sel | input | 3 | Command/register select code |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Last byte read from guest RAM |
| host_rvalid | output | 1 | host_rdata holds a completed read |
| mode_o | output | 1 | 0 classic 4-bit shift, 1 wide 8-bit shift |
| ram_addr | output | 24 | Guest RAM byte address |
| ram_rd | output | 1 | Guest RAM read enable |
| ram_wr | output | 1 | Guest RAM write enable |
| ram_wdata | output | 8 | Guest RAM write byte |
| ram_rdata | input | 8 | Guest RAM read byte (combinational in the model) |

## Verification
The translation is tried in both modes on a grid of segment and offset values stepped by 0x1111, so that every nibble takes every value at once. This pattern reaches full carry chains and the all-ones corner, where the classic mode must drop bit 20 and the wide mode must wrap at 2^24. Walking-one patterns on the segment alone and on the offset alone show whether each bit lands at the right position for each shift, which separates a wrong shift amount from a wrong slice carry. Read-before-write and write-then-read sequences at several addresses check the strobe timing. A phase with the strobe held low and the select lines toggling shows that idle inputs are ignored.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int BYTE_W     = 8;
    localparam int SEG_W      = 2 * BYTE_W;
    localparam int OFF_W      = 2 * BYTE_W;
    localparam int SEL_W      = 3;
    localparam int N_SEL      = 1 << SEL_W;
    localparam int NORM_SHIFT = 4;
    localparam int WIDE_SHIFT = 8;
    localparam int ADDR_W     = SEG_W + WIDE_SHIFT;
    localparam int NORM_W     = SEG_W + NORM_SHIFT;

    // Command codes on the select lines
    typedef enum logic [SEL_W-1:0] {
        SEL_OFF_LO = 3'd0,
        SEL_OFF_HI = 3'd1,
        SEL_SEG_LO = 3'd2,
        SEL_SEG_HI = 3'd3,
        SEL_RD     = 3'd4,
        SEL_WR     = 3'd5,
        SEL_NORM   = 3'd6,
        SEL_WIDE   = 3'd7
    } sel_code_e;

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [OFF_W-1:0]  off;
        logic              wide;
        logic              rd;
        logic              wr;
        logic [BYTE_W-1:0] wdata;
        logic [BYTE_W-1:0] rdata;
        logic              rvalid;
    } xlate_state_t;

endpackage

// File: rtl/seg_xlate_sel_decode.sv
module seg_xlate_sel_decode #(
    parameter int SEL_W = 3,
    localparam int N_OUT = 1 << SEL_W
) (
    input  logic             stb,
    input  logic [SEL_W-1:0] sel,
    output logic [N_OUT-1:0] hit
);
    // One-hot decode gated by the strobe
    for (genvar i = 0; i < N_OUT; i++) begin : g_line
        assign hit[i] = stb && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/seg_xlate_ripple.sv
module seg_xlate_ripple #(
    parameter int WIDTH   = 24,
    parameter int SLICE_W = 4,
    localparam int N_SLICE = WIDTH / SLICE_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum
);
    // carry[i] is the carry into slice i
    logic [N_SLICE-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
        logic [SLICE_W-1:0] sa;
        logic [SLICE_W-1:0] sb;
        assign sa = a[i*SLICE_W +: SLICE_W];
        assign sb = b[i*SLICE_W +: SLICE_W];
        if (i < N_SLICE - 1) begin : g_mid
            logic [SLICE_W:0] part;
            assign part = {1'b0, sa} + {1'b0, sb} + {{SLICE_W{1'b0}}, carry[i]};
            assign sum[i*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
            assign carry[i+1] = part[SLICE_W];
        end else begin : g_top
            // Final slice: carry out wraps
            assign sum[i*SLICE_W +: SLICE_W] = sa + sb + {{(SLICE_W-1){1'b0}}, carry[i]};
        end
    end
endmodule

// File: rtl/seg_xlate_regs.sv
module seg_xlate_regs
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SEL-1:0]  hit,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [BYTE_W-1:0] ram_rdata,
    output xlate_state_t      state_q
);
    xlate_state_t state_d;

    always_comb begin
        state_d    = state_q;
        state_d.rd = 1'b0;
        state_d.wr = 1'b0;

        if (state_q.rd) begin
            state_d.rdata  = ram_rdata;
            state_d.rvalid = 1'b1;
        end

        if (hit[SEL_OFF_LO]) state_d.off[BYTE_W-1:0]      = host_wdata;
        if (hit[SEL_OFF_HI]) state_d.off[OFF_W-1:BYTE_W]  = host_wdata;
        if (hit[SEL_SEG_LO]) state_d.seg[BYTE_W-1:0]      = host_wdata;
        if (hit[SEL_SEG_HI]) state_d.seg[SEG_W-1:BYTE_W]  = host_wdata;

        if (hit[SEL_RD]) begin
            state_d.rd     = 1'b1;
            state_d.rvalid = 1'b0;
        end
        if (hit[SEL_WR]) begin
            state_d.wr    = 1'b1;
            state_d.wdata = host_wdata;
        end

        if (hit[SEL_NORM]) state_d.wide = 1'b0;
        if (hit[SEL_WIDE]) state_d.wide = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_stb,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              mode_o,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [BYTE_W-1:0] ram_wdata,
    input  logic [BYTE_W-1:0] ram_rdata
);
    localparam logic [ADDR_W-1:0] NORM_MASK = ADDR_W'((1 << NORM_W) - 1);

    logic [N_SEL-1:0]  hit;
    xlate_state_t      st_q;
    logic [ADDR_W-1:0] seg_shifted;
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] raw_sum;

    seg_xlate_sel_decode #(.SEL_W(SEL_W)) u_dec (
        .stb (host_stb),
        .sel (host_sel),
        .hit (hit)
    );

    seg_xlate_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .host_wdata (host_wdata),
        .ram_rdata  (ram_rdata),
        .state_q    (st_q)
    );

    always_comb begin
        if (st_q.wide) seg_shifted = ADDR_W'(st_q.seg) << WIDE_SHIFT;
        else           seg_shifted = ADDR_W'(st_q.seg) << NORM_SHIFT;
        off_ext = ADDR_W'(st_q.off);
    end

    seg_xlate_ripple #(.WIDTH(ADDR_W), .SLICE_W(SLICE_W)) u_add (
        .a   (seg_shifted),
        .b   (off_ext),
        .sum (raw_sum)
    );

    assign ram_addr    = st_q.wide ? raw_sum : (raw_sum & NORM_MASK);
    assign mode_o      = st_q.wide;
    assign ram_rd      = st_q.rd;
    assign ram_wr      = st_q.wr;
    assign ram_wdata   = st_q.wdata;
    assign host_rdata  = st_q.rdata;
    assign host_rvalid = st_q.rvalid;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_stb,
    input logic [SEL_W-1:0]  host_sel,
    input logic              mode_o,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_rd,
    input logic              ram_wr,
    input logic              host_rvalid,
    input logic [BYTE_W-1:0] host_rdata,
    input logic [BYTE_W-1:0] ram_rdata
);
    assert_norm_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o |-> ram_addr[ADDR_W-1:NORM_W] == '0);

    assert_mode_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stb && host_sel == SEL_WIDE) |=> mode_o);

    assert_mode_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stb && host_sel == SEL_NORM) |=> !mode_o);

    assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |=> !ram_rd);

    assert_rd_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |=> (host_rvalid && host_rdata == $past(ram_rdata)));

    assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |=> !ram_wr);

    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_stb |=> ($stable(ram_addr) && $stable(mode_o) && !ram_rd && !ram_wr));

    assert_rvalid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> !host_rvalid);

    assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_stb    (host_stb),
    .host_sel    (host_sel),
    .mode_o      (mode_o),
    .ram_addr    (ram_addr),
    .ram_rd      (ram_rd),
    .ram_wr      (ram_wr),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata),
    .ram_rdata   (ram_rdata)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    import seg_xlate_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RAM_AW     = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_stb = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        mode_o;
    logic [23:0] ram_addr;
    logic        ram_rd;
    logic        ram_wr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem [0:(1<<RAM_AW)-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate u_dut (
        .clk (clk), .rst_n (rst_n),
        .host_stb (host_stb), .host_sel (host_sel), .host_wdata (host_wdata),
        .host_rdata (host_rdata), .host_rvalid (host_rvalid), .mode_o (mode_o),
        .ram_addr (ram_addr), .ram_rd (ram_rd), .ram_wr (ram_wr),
        .ram_wdata (ram_wdata), .ram_rdata (ram_rdata)
    );

    // Guest RAM model: combinational read, write on the clock edge
    assign ram_rdata = mem[ram_addr[RAM_AW-1:0]];
    always @(posedge clk) if (ram_wr) mem[ram_addr[RAM_AW-1:0]] <= ram_wdata;

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 7) + 3);
    endfunction

    function automatic logic [31:0] exp_addr(logic wide, logic [15:0] s, logic [15:0] o);
        if (wide) return ((32'(s) << 8) + 32'(o)) & 32'hFF_FFFF;
        else      return ((32'(s) << 4) + 32'(o)) & 32'h0F_FFFF;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One strobed command; returns at the falling edge after the capturing edge
    task automatic host_op(sel_code_e code, logic [7:0] data);
        @(negedge clk);
        host_stb   = 1'b1;
        host_sel   = code;
        host_wdata = data;
        @(negedge clk);
        host_stb   = 1'b0;
    endtask

    task automatic load(logic [15:0] s, logic [15:0] o);
        host_op(SEL_OFF_LO, o[7:0]);
        host_op(SEL_OFF_HI, o[15:8]);
        host_op(SEL_SEG_LO, s[7:0]);
        host_op(SEL_SEG_HI, s[15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << RAM_AW); i++) mem[i] = init_byte(i);

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 addr", 32'(ram_addr), 0);
        check("R1 mode", 32'(mode_o), 0);
        check("R1 rd/wr/rvalid", {29'b0, ram_rd, ram_wr, host_rvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 addr after release", 32'(ram_addr), 0);

        // R2/R3/R4: nibble-grid sweep in both modes
        for (int m = 0; m < 2; m++) begin
            host_op(m ? SEL_WIDE : SEL_NORM, 8'h5A);
            check("R5 mode", 32'(mode_o), 32'(m));
            for (int si = 0; si < 16; si++) begin
                for (int oi = 0; oi < 16; oi++) begin
                    logic [15:0] s;
                    logic [15:0] o;
                    s = 16'(si * 16'h1111);
                    o = 16'(oi * 16'h1111);
                    load(s, o);
                    check(m ? "R4 grid" : "R3 grid", 32'(ram_addr), exp_addr(m[0], s, o));
                end
            end
        end

        // R2/R3/R4: walking ones on segment and on offset
        for (int m = 0; m < 2; m++) begin
            host_op(m ? SEL_WIDE : SEL_NORM, 8'hFF);
            for (int b = 0; b < 16; b++) begin
                load(16'(1 << b), 16'h0);
                check("R2 seg walk", 32'(ram_addr), exp_addr(m[0], 16'(1 << b), 16'h0));
                load(16'h0, 16'(1 << b));
                check("R2 off walk", 32'(ram_addr), exp_addr(m[0], 16'h0, 16'(1 << b)));
            end
        end

        // R3: carry out of bit 19 dropped; R4: wrap at 2^24
        host_op(SEL_NORM, 8'h00);
        load(16'hFFFF, 16'hFFFF);
        check("R3 wrap", 32'(ram_addr), 32'h0_FFEF);
        host_op(SEL_WIDE, 8'h00);
        check("R4 wrap", 32'(ram_addr), 32'h00_FEFF);

        // R8: idle strobe ignores select and data
        @(negedge clk);
        host_sel   = SEL_NORM;
        host_wdata = 8'h33;
        repeat (3) @(negedge clk);
        check("R8 mode held", 32'(mode_o), 1);
        check("R8 addr held", 32'(ram_addr), 32'h00_FEFF);
        host_sel = SEL_RD;
        repeat (2) @(negedge clk);
        check("R8 no access", {30'b0, ram_rd, ram_wr}, 0);

        // R6/R7/R9: read, write, read back
        host_op(SEL_NORM, 8'h00);
        for (int k = 0; k < 8; k++) begin
            logic [15:0] s;
            logic [15:0] o;
            logic [31:0] a;
            s = 16'(k * 3);
            o = 16'(k * 16'h0123);
            a = exp_addr(1'b0, s, o);
            load(s, o);
            host_op(SEL_RD, 8'h00);
            check("R6 rd high", 32'(ram_rd), 1);
            check("R9 rvalid low", 32'(host_rvalid), 0);
            @(negedge clk);
            check("R6 rd pulse", 32'(ram_rd), 0);
            check("R6 rvalid", 32'(host_rvalid), 1);
            check("R6 rdata", 32'(host_rdata), 32'(init_byte(int'(a[RAM_AW-1:0]))));
            host_op(SEL_WR, 8'(8'hA0 + k));
            check("R7 wr high", 32'(ram_wr), 1);
            check("R10 exclusive", 32'(ram_rd), 0);
            check("R7 wdata", 32'(ram_wdata), 32'(8'hA0 + k));
            check("R7 addr", 32'(ram_addr), a);
            @(negedge clk);
            check("R7 wr pulse", 32'(ram_wr), 0);
            host_op(SEL_RD, 8'h00);
            @(negedge clk);
            check("R7 readback", 32'(host_rdata), 32'(8'hA0 + k));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule